// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Bank

This block holds the configuration and monitoring registers of a line-driver interface: four 8-bit registers reached through a 2-bit address over a plain register port. The port has a write enable and a single-cycle read strobe. A serial transport is expected to sit in front of this port. The status register is the centre of the block. It latches six interrupt flags from fault and event detectors, reports two live line levels, and drives an interrupt request output.

A status read returns the flags as they stood before the read and clears them in the same cycle. A condition that is still high in the cycle of the read sets its flag again at once, so the request stays up until every cause has gone. The wake-up source only latches while its enable bit in the mode register is set. An output-driver fault is recorded twice: once in status and once as a sticky flag in the mode register.

The request output is decoded from a two-state machine. **IRQ_IDLE** means no flag is pending and **IRQ_RAISED** means at least one flag is pending. The **RAISE** transition fires when the next flag vector is non-zero. The **CLEAR** transition fires when it becomes all zero. A parameter inverts the output polarity.

Top module: `lsr_status_bank`

## Requirements
- R1: After reset all six interrupt flags, the request state, the read data, and the line-configuration, output-configuration and mode registers are 0.
- R2: Address 01 (line configuration) and address 10 (output configuration) read back any written byte. Address 11 (mode) reads back every written bit except bit 5.
- R3: The status byte is laid out, from bit 7 to bit 0, as: wake-up, output fault, inverted logic-input level, line level, line fault, 3.3 V undervoltage, 24 V undervoltage, overtemperature.
- R4: A write to address 00 leaves the status register unchanged.
- R5: A status read (rd_en high with addr 00) registers the status byte into rd_data at that clock edge and clears all six flags there. The two live-level bits are unaffected by the read.
- R6: If a source is still high in the cycle of a status read, its flag is set again at that edge, and the following read reports it again.
- R7: The wake-up flag is set only when wake_det is high while mode bit 6 (wake enable) is 1.
- R8: The request is active whenever any flag is 1 and inactive once all flags are 0. It is active-high when IRQ_ACTIVE_LOW is 0 and active-low when IRQ_ACTIVE_LOW is 1.
- R9: Status bit 5 equals the inverse of li_level and status bit 4 equals line_level. Neither bit ever affects the request.
- R10: An out_flt pulse sets both status bit 6 and mode bit 5. Mode bit 5 ignores written 0s and is cleared by writing 1 to it.
- R11: A source pulse that arrives in the same cycle as a status read is not lost: it appears in the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_en |
| wake_det | input | 1 | Wake-up pulse detected |
| out_flt | input | 1 | Output-driver fault condition |
| line_flt | input | 1 | Line-driver fault condition |
| uv33_det | input | 1 | 3.3 V undervoltage detected |
| uv24_det | input | 1 | 24 V undervoltage detected |
| otemp_det | input | 1 | Overtemperature detected |
| li_level | input | 1 | Logic-input output level |
| line_level | input | 1 | Live line level |
| irq | output | 1 | Interrupt request, polarity set by IRQ_ACTIVE_LOW |

## Verification
The bench builds two copies of the block side by side on the same stimulus: one with IRQ_ACTIVE_LOW at 0 and one with it at 1. Every request check therefore covers both polarities of the output decode. The register width and address width keep their defaults of 8 and 2, the only values the fixed status layout supports. With these settings every address, every flag position and the read/set collision cycle can each be reached with a handful of directed pulses.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int N_FLAG = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_STATUS  = 2'b00,
        A_LINECFG = 2'b01,
        A_OUTCFG  = 2'b10,
        A_MODE    = 2'b11
    } reg_addr_e;

    // flag vector index order: wake, out fault, line fault, uv33, uv24, otemp
    localparam int F_WAKE = 5;
    localparam int F_OFLT = 4;
    localparam int F_LFLT = 3;
    localparam int F_UV33 = 2;
    localparam int F_UV24 = 1;
    localparam int F_OTMP = 0;

    localparam int M_WAKE_EN = 6;
    localparam int M_OFLT    = 5;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/lsr_flag_bank.sv
module lsr_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] flag_nxt_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_flag
            logic q;
            // set wins over clear so a live cause survives the read
            assign flag_nxt_o[g] = (q & ~clr_i) | set_i[g];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b0;
                else        q <= flag_nxt_o[g];
            end
            assign flag_o[g] = q;
        end
    endgenerate
endmodule

// File: rtl/lsr_cfg_regs.sv
module lsr_cfg_regs
    import lsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              oflt_set,
    output logic [REG_W-1:0]  line_cfg_o,
    output logic [REG_W-1:0]  out_cfg_o,
    output logic [REG_W-1:0]  mode_o
);
    logic [REG_W-1:0] line_q, out_q, mode_q;
    logic             oflt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            out_q  <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            unique case (reg_addr_e'(addr))
                A_LINECFG: line_q <= wr_data;
                A_OUTCFG:  out_q  <= wr_data;
                A_MODE: begin
                    mode_q[REG_W-1:M_OFLT+1] <= wr_data[REG_W-1:M_OFLT+1];
                    mode_q[M_OFLT-1:0]       <= wr_data[M_OFLT-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   oflt_q <= 1'b0;
        else if (oflt_set)                            oflt_q <= 1'b1;
        else if (wr_en && reg_addr_e'(addr) == A_MODE
                 && wr_data[M_OFLT])                  oflt_q <= 1'b0;
    end

    assign line_cfg_o = line_q;
    assign out_cfg_o  = out_q;
    assign mode_o     = {mode_q[REG_W-1:M_OFLT+1], oflt_q, mode_q[M_OFLT-1:0]};
endmodule

// File: rtl/lsr_irq_ctrl.sv
module lsr_irq_ctrl
    import lsr_pkg::*;
#(
    parameter bit IRQ_INV = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nxt,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pend_nxt)  state_d = IRQ_RAISED; // RAISE
            IRQ_RAISED: if (!pend_nxt) state_d = IRQ_IDLE;   // CLEAR
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED) ^ IRQ_INV;
    end
endmodule

// File: rtl/lsr_status_bank.sv
module lsr_status_bank
    import lsr_pkg::*;
#(
    parameter bit IRQ_ACTIVE_LOW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    input  logic              wake_det,
    input  logic              out_flt,
    input  logic              line_flt,
    input  logic              uv33_det,
    input  logic              uv24_det,
    input  logic              otemp_det,
    input  logic              li_level,
    input  logic              line_level,
    output logic              irq
);
    logic [REG_W-1:0]  line_cfg, out_cfg, mode_q;
    logic [N_FLAG-1:0] src_set, stat_flags, flags_nxt;
    logic [REG_W-1:0]  status_byte, rd_mux;
    logic              rd_status;

    assign rd_status = rd_en && (reg_addr_e'(addr) == A_STATUS);

    always_comb begin
        src_set         = '0;
        src_set[F_WAKE] = wake_det & mode_q[M_WAKE_EN];
        src_set[F_OFLT] = out_flt;
        src_set[F_LFLT] = line_flt;
        src_set[F_UV33] = uv33_det;
        src_set[F_UV24] = uv24_det;
        src_set[F_OTMP] = otemp_det;
    end

    lsr_flag_bank #(.N(N_FLAG)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (src_set),
        .clr_i      (rd_status),
        .flag_o     (stat_flags),
        .flag_nxt_o (flags_nxt)
    );

    lsr_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .oflt_set   (out_flt),
        .line_cfg_o (line_cfg),
        .out_cfg_o  (out_cfg),
        .mode_o     (mode_q)
    );

    lsr_irq_ctrl #(.IRQ_INV(IRQ_ACTIVE_LOW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_nxt (|flags_nxt),
        .irq_o    (irq)
    );

    assign status_byte = {stat_flags[F_WAKE], stat_flags[F_OFLT], ~li_level, line_level,
                          stat_flags[F_LFLT], stat_flags[F_UV33],
                          stat_flags[F_UV24], stat_flags[F_OTMP]};

    always_comb begin
        unique case (reg_addr_e'(addr))
            A_STATUS:  rd_mux = status_byte;
            A_LINECFG: rd_mux = line_cfg;
            A_OUTCFG:  rd_mux = out_cfg;
            A_MODE:    rd_mux = mode_q;
        endcase
    end

    // sampled at the same edge that clears the flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end
endmodule

// File: rtl/lsr_status_chk.sv
module lsr_status_chk #(
    parameter bit IRQ_INV = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic       out_flt,
    input logic       irq,
    input logic [5:0] src_set,
    input logic [5:0] stat_flags,
    input logic [7:0] mode_q
);
    // R5
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'b00 && src_set == 6'd0) |=> stat_flags == 6'd0);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != 6'd0) |=> ((stat_flags & $past(src_set)) == $past(src_set)));

    // R4
    status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == 2'b00 && src_set == 6'd0) |=> $stable(stat_flags));

    // R7
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[6] && !stat_flags[5]) |=> !stat_flags[5]);

    // R8
    irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq ^ IRQ_INV) == (|stat_flags)));

    // R10
    oflt_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_flt |=> (mode_q[5] && stat_flags[4]));
endmodule

bind lsr_status_bank lsr_status_chk #(.IRQ_INV(IRQ_ACTIVE_LOW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .out_flt    (out_flt),
    .irq        (irq),
    .src_set    (src_set),
    .stat_flags (stat_flags),
    .mode_q     (mode_q)
);

// File: tb/sim_lsr_status_bank.sv
`timescale 1ns/1ps
module sim_lsr_status_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'b00;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [5:0] src = 6'd0; // [5]wake [4]out [3]line [2]uv33 [1]uv24 [0]otemp
    logic       li_level = 1'b1, line_level = 1'b0;
    logic [7:0] rd_data, rd_data1;
    logic       irq, irq1;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    lsr_status_bank #(.IRQ_ACTIVE_LOW(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .wake_det(src[5]), .out_flt(src[4]),
        .line_flt(src[3]), .uv33_det(src[2]), .uv24_det(src[1]), .otemp_det(src[0]),
        .li_level(li_level), .line_level(line_level), .irq(irq));

    lsr_status_bank #(.IRQ_ACTIVE_LOW(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data1), .wake_det(src[5]), .out_flt(src[4]),
        .line_flt(src[3]), .uv33_det(src[2]), .uv24_det(src[1]), .otemp_det(src[0]),
        .li_level(li_level), .line_level(line_level), .irq(irq1));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_irq(input string req, input logic exp);
        chk(req, {7'd0, irq}, {7'd0, exp});
        chk(req, {7'd0, irq1}, {7'd0, ~exp});
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic pulse(input logic [5:0] s);
        @(negedge clk); src = s;
        @(negedge clk); src = 6'd0;
    endtask

    task automatic t_reset;
        chk("R1 rd_data", rd_data, 8'h00);
        chk_irq("R1 irq", 1'b0);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], rv);
            chk("R1 reg", rv, 8'h00);
        end
    endtask

    task automatic t_cfg_rw;
        wr(2'b01, 8'hA5); wr(2'b10, 8'h3C); wr(2'b11, 8'h9F);
        rd(2'b01, rv); chk("R2 line cfg", rv, 8'hA5);
        rd(2'b10, rv); chk("R2 out cfg", rv, 8'h3C);
        rd(2'b11, rv); chk("R2 mode", rv, 8'h9F & 8'hDF);
        wr(2'b11, 8'h00);
    endtask

    task automatic t_status_ro;
        wr(2'b00, 8'hFF);
        chk_irq("R4 irq", 1'b0);
        rd(2'b00, rv); chk("R4 status after write", rv, 8'h00);
    endtask

    task automatic t_layout;
        logic [7:0] pos [5];
        pos = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h40};
        for (int i = 0; i < 5; i++) begin
            pulse(6'd1 << i);
            chk_irq("R8 raised", 1'b1);
            rd(2'b00, rv); chk("R3 bit position", rv, pos[i]);
            chk_irq("R8 cleared", 1'b0);
            rd(2'b00, rv); chk("R5 cleared", rv, 8'h00);
        end
    endtask

    task automatic t_live;
        @(negedge clk); li_level = 1'b0; line_level = 1'b1;
        @(negedge clk);
        chk_irq("R9 no irq", 1'b0);
        rd(2'b00, rv); chk("R9 live bits", rv, 8'h30);
        rd(2'b00, rv); chk("R5 live kept", rv, 8'h30);
        @(negedge clk); li_level = 1'b1; line_level = 1'b0;
    endtask

    task automatic t_persist;
        @(negedge clk); src = 6'b001000;
        rd(2'b00, rv); chk("R6 first", rv, 8'h08);
        rd(2'b00, rv); chk("R6 relatched", rv, 8'h08);
        chk_irq("R6 irq held", 1'b1);
        @(negedge clk); src = 6'd0;
        rd(2'b00, rv); chk("R6 last", rv, 8'h08);
        rd(2'b00, rv); chk("R6 gone", rv, 8'h00);
        chk_irq("R8 idle", 1'b0);
    endtask

    task automatic t_wake;
        pulse(6'b100000);
        chk_irq("R7 gated", 1'b0);
        rd(2'b00, rv); chk("R7 gated", rv, 8'h00);
        wr(2'b11, 8'h40);
        pulse(6'b100000);
        chk_irq("R7 enabled", 1'b1);
        rd(2'b00, rv); chk("R7 enabled", rv, 8'h80);
        chk_irq("R7 cleared", 1'b0);
    endtask

    task automatic t_oflt_mode;
        pulse(6'b010000);
        rd(2'b11, rv); chk("R10 mode flag", rv, 8'h60);
        rd(2'b00, rv); chk("R10 status", rv, 8'h40);
        wr(2'b11, 8'h40);
        rd(2'b11, rv); chk("R10 write 0 ignored", rv, 8'h60);
        wr(2'b11, 8'h60);
        rd(2'b11, rv); chk("R10 w1c", rv, 8'h40);
    endtask

    task automatic t_same_cycle;
        pulse(6'b000001);
        @(negedge clk); addr = 2'b00; rd_en = 1'b1; src = 6'b000010;
        @(negedge clk); rd_en = 1'b0; src = 6'd0; rv = rd_data;
        chk("R11 first read", rv, 8'h01);
        chk_irq("R11 irq held", 1'b1);
        rd(2'b00, rv); chk("R11 kept", rv, 8'h02);
        chk_irq("R11 idle", 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_rw();
        t_status_ro();
        t_layout();
        t_live();
        t_persist();
        t_wake();
        t_oflt_mode();
        t_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule